// File: doc/BRIEF.md
# Overwriting Sample Buffer With In-Word Status

This block sits between a measurement engine and a host-facing read port. Each conversion result from the engine is 12 bits wide and comes with a one-bit tag that tells which of two measurement channels produced it. The block stores these results in a 64-slot circular buffer. The host takes one sample per read strobe. It gets back a 16-bit word that holds the sample, its tag and two status flags, so it never has to poll a separate status location.

The buffer favours fresh data. When all 64 slots hold unread samples, a new sample replaces the oldest one and the read position moves forward with it. A hold control can stop incoming samples while the host is reading. In automatic mode, a read-in-progress input from the host interface freezes writes. In software mode, a hold bit freezes writes. A sample that arrives during a hold is thrown away and reported with a one-cycle pulse. Dropping the buffer enable empties the buffer and returns the read word to its idle value.

Top module: `sample_fifo_flags`

## Requirements
- R1: After reset, and on the cycle after any cycle with `buf_en` low, `rd_word` equals 16'h4000 and `held_drop` is 0.
- R2: Samples are returned in the order they were accepted, and up to 64 samples are stored without loss.
- R3: Read word layout: bit 15 is the full flag, bit 14 the empty flag, bit 13 always 0, bit 12 the sample tag, and bits 11..0 the sample value. `rd_word` is updated on the clock edge that samples `rd_strobe` high.
- R4: The full flag in a read word is 1 exactly when 64 unread samples were stored at the moment of the read.
- R5: The empty flag is 1 in the word that returns the last unread sample. It is also 1 on a read of an empty buffer, which returns tag 0 and value 0 and does not move the read position.
- R6: An accepted write into a full buffer with no read in the same cycle replaces the oldest sample. The buffer keeps 64 unread samples.
- R7: With `hold_sel` = 0, a write is dropped while `rd_active` is 1, and `hold_sw` has no effect.
- R8: With `hold_sel` = 1, a write is dropped while `hold_sw` is 1, and `rd_active` has no effect.
- R9: A write dropped by a hold raises `held_drop` for one cycle, on the cycle after the write.
- R10: With `buf_en` low, every stored sample is discarded. After `buf_en` goes high again, the first read returns the empty word.
- R11: A read and an accepted write in the same cycle on a full buffer pop the oldest sample and store the new one. Nothing is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_en | input | 1 | Buffer enable; low clears the buffer |
| wr_valid | input | 1 | Sample strobe from the measurement engine |
| wr_data | input | 12 | Sample value |
| wr_id | input | 1 | Sample channel tag |
| rd_strobe | input | 1 | Host read request, one word per cycle high |
| rd_active | input | 1 | Host read transaction in progress (automatic hold source) |
| hold_sel | input | 1 | Hold mode: 0 automatic, 1 software |
| hold_sw | input | 1 | Software hold bit |
| rd_word | output | 16 | Formatted read word |
| held_drop | output | 1 | One-cycle pulse for a sample lost to a hold |

## Verification
The bench fills the buffer to exactly 64 slots and drains it. A design with an off-by-one capacity would either lose the first sample or never raise the full flag. It then writes past full and checks that the first words read back are the newest survivors and not the discarded ones; a design that did not advance the read position would return stale samples. It also reads an empty buffer and then writes one sample, which catches a read position that moves on an empty read, and it performs a simultaneous read and write on a full buffer, where a wrong design would drop a second sample. Both hold modes are run with the unused control set to its blocking value, so a design that mixes up the modes drops or keeps the wrong samples.

// File: rtl/sample_fifo_flags.sv
module sample_fifo_flags #(
  parameter int DEPTH = 64,
  parameter int DW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_en,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_id,
  input  logic          rd_strobe,
  input  logic          rd_active,
  input  logic          hold_sel,
  input  logic          hold_sw,
  output logic [DW+3:0] rd_word,
  output logic          held_drop
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = DW + 4;
  localparam logic [WW-1:0] IDLE_WORD = WW'(1) << (WW - 2);

  logic [DW:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  logic wr_hold, wr_ok, rd_ok, is_empty, is_full, pop, overwrite, last_one;

  // Hold source is picked by the mode bit; the other source is ignored.
  assign wr_hold   = hold_sel ? hold_sw : rd_active;
  assign wr_ok     = buf_en & wr_valid & ~wr_hold;
  assign rd_ok     = buf_en & rd_strobe;
  assign is_empty  = (cnt == '0);
  assign is_full   = (cnt == CW'(DEPTH));
  assign last_one  = (cnt <= CW'(1));
  assign pop       = rd_ok & ~is_empty;
  assign overwrite = wr_ok & is_full & ~pop;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= {wr_id, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      rd_word   <= IDLE_WORD;
      held_drop <= 1'b0;
    end else if (!buf_en) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      rd_word   <= IDLE_WORD;
      held_drop <= 1'b0;
    end else begin
      held_drop <= wr_valid & wr_hold;
      if (wr_ok) wp <= wp + PW'(1);
      if (pop | overwrite) rp <= rp + PW'(1);
      if (wr_ok & ~is_full & ~pop)
        cnt <= cnt + CW'(1);
      else if (pop & ~wr_ok)
        cnt <= cnt - CW'(1);
      if (rd_ok)
        rd_word <= {is_full, last_one, 1'b0, pop ? mem[rp] : {(DW+1){1'b0}}};
    end
  end

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[WW-3] == 1'b0);

  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_word[WW-1] && rd_word[WW-2]));

  // R1
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |=> (rd_word == IDLE_WORD) && !held_drop);

  // R9
  drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_drop |-> $past(wr_valid && buf_en));

  // R6
  overwrite_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && overwrite) |=> (cnt == CW'(DEPTH)));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && rd_strobe && is_empty && !wr_valid) |=> (rp == $past(rp)));
endmodule

// File: tb/test_sample_fifo_flags.sv
module test_sample_fifo_flags;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        buf_en = 0;
  logic        wr_valid = 0;
  logic [11:0] wr_data = 0;
  logic        wr_id = 0;
  logic        rd_strobe = 0;
  logic        rd_active = 0;
  logic        hold_sel = 0;
  logic        hold_sw = 0;
  logic [15:0] rd_word;
  logic        held_drop;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  logic [12:0] model[$];
  logic [15:0] sb_exp[$];
  string       sb_req[$];
  logic        rd_seen = 0;

  sample_fifo_flags i_sample_fifo_flags (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_id(wr_id), .rd_strobe(rd_strobe),
    .rd_active(rd_active), .hold_sel(hold_sel), .hold_sw(hold_sw),
    .rd_word(rd_word), .held_drop(held_drop));

  always #10ns clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    logic [15:0] w;
    if (model.size() == 0) w = 16'h4000;
    else w = {model.size() == 64, model.size() <= 1, 1'b0, model[0]};
    return w;
  endfunction

  always @(posedge clk) rd_seen <= rd_strobe & buf_en;

  // monitor: pops the scoreboard once per completed read
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_exp.size() == 0) begin
        checks++; bad++;
        $display("FAIL R2 actual=%h expected=none", rd_word);
      end else begin
        check(sb_req.pop_front(), rd_word, sb_exp.pop_front());
      end
    end
  end

  task automatic wr(int seed, bit exp_acc, bit exp_drop, string req);
    logic [12:0] s = {seed[0], 12'((seed * 37 + 5))};
    wr_valid = 1; wr_id = s[12]; wr_data = s[11:0];
    @(negedge clk);
    wr_valid = 0;
    check({req, " held_drop"}, {15'd0, held_drop}, {15'd0, exp_drop});
    if (exp_acc) begin
      if (model.size() == 64) void'(model.pop_front());
      model.push_back(s);
    end
  endtask

  task automatic rd(string req);
    sb_exp.push_back(exp_word());
    sb_req.push_back(req);
    if (model.size() != 0) void'(model.pop_front());
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
  endtask

  task automatic rdwr(int seed, string req);
    logic [12:0] s = {seed[0], 12'((seed * 37 + 5))};
    sb_exp.push_back(exp_word());
    sb_req.push_back(req);
    if (model.size() != 0) void'(model.pop_front());
    model.push_back(s);
    rd_strobe = 1; wr_valid = 1; wr_id = s[12]; wr_data = s[11:0];
    @(negedge clk);
    rd_strobe = 0; wr_valid = 0;
  endtask

  task automatic drain(string req);
    while (model.size() != 0) rd(req);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset word", rd_word, 16'h4000);
    check("R1 reset drop", {15'd0, held_drop}, 16'd0);
    buf_en = 1;
    @(negedge clk);

    // short burst, then empty read
    for (int i = 1; i <= 3; i++) wr(i, 1, 0, "R2");
    rd("R3 layout"); rd("R2 order"); rd("R5 last unread");
    rd("R5 empty read");

    // empty read must not move the read position
    wr(40, 1, 0, "R5");
    rd("R5 after empty read");

    // exact capacity
    for (int i = 100; i < 164; i++) wr(i, 1, 0, "R2");
    drain("R4 R2 full drain");

    // overwrite past full
    for (int i = 200; i < 267; i++) wr(i, 1, 0, "R6");
    drain("R6 overwrite");

    // automatic hold
    hold_sel = 0; rd_active = 1;
    wr(300, 0, 1, "R7 R9 auto hold");
    @(negedge clk);
    check("R9 pulse one cycle", {15'd0, held_drop}, 16'd0);
    rd_active = 0; hold_sw = 1;
    wr(301, 1, 0, "R7 sw bit ignored");
    // software hold
    hold_sel = 1; hold_sw = 1;
    wr(302, 0, 1, "R8 R9 sw hold");
    hold_sw = 0; rd_active = 1;
    wr(303, 1, 0, "R8 rd_active ignored");
    rd_active = 0; hold_sel = 0;
    drain("R7 R8 hold contents");

    // read and write together on full
    for (int i = 400; i < 464; i++) wr(i, 1, 0, "R11");
    rdwr(500, "R11 simultaneous");
    drain("R11 after simultaneous");

    // disable clears
    for (int i = 600; i < 605; i++) wr(i, 1, 0, "R10");
    buf_en = 0;
    @(negedge clk);
    check("R1 disabled word", rd_word, 16'h4000);
    model.delete();
    buf_en = 1;
    @(negedge clk);
    rd("R10 empty after enable");
    wr(700, 1, 0, "R10");
    rd("R10 fresh sample");

    @(negedge clk);
    @(negedge clk);
    check("R2 scoreboard empty", 16'(sb_exp.size()), 16'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule